// File: doc/BRIEF.md
# Translation Lookaside Cache with Invalidate and Probe

A small, fully associative cache of virtual-to-physical translations. Each of its entries holds a 32-bit page table entry, the context number it belongs to, the virtual page tag, and the walk level at which the mapping ended. Level 1 maps 16 MiB, level 2 maps 256 KiB and level 3 maps 4 KiB. A lookup compares only as many tag bits as the entry's level covers. On a hit it returns the physical address and the entry in the same cycle. On a miss it raises a flag so that an external table walker can fetch the mapping and write it back through the fill port.

A control port carries invalidate writes and probe reads. Address bits [11:8] of a control access select the operation. The invalidate operations work on a page, a segment, a region, a whole context, or the whole cache. Entries with large mappings are removed by any invalidate whose address range overlaps them. A probe read returns the stored entry for an address, or zero.

Top module: `xlat_cache`

## Requirements
- R1: After reset every entry is invalid. Any lookup misses and any probe returns zero.
- R2: A level-3 entry (fill level 3) hits when VA[31:12] and the context match. The physical address is {pte[27:8], va[11:0]} and the entry appears on lk_pte_o. Both outputs are valid in the same cycle as the lookup.
- R3: A level-1 entry compares only VA[31:24] and gives the physical address {pte[27:20], va[23:0]}. A level-2 entry compares only VA[31:18] and gives {pte[27:14], va[17:0]}.
- R4: An entry hits only while ctx_i equals the context that ctx_i held when the entry was filled.
- R5: When lk_valid_i is 1 and no entry matches, lk_miss_o is 1 and lk_hit_o is 0. When lk_valid_i is 0, both flags are 0.
- R6: A fill writes the lowest-indexed invalid entry. When all entries are valid, a fill writes the entry at a round-robin pointer. The pointer starts at 0 and advances by one, with wrap-around, after each such fill.
- R7: A control write with bits [11:8] = 0 invalidates entries for a page. The overlap test uses VA[31:12] together with the entry's own coarser range, so a level-1 or level-2 entry that contains the page is also removed.
- R8: A control write with code 1 (segment) compares VA[31:18]. A control write with code 2 (region) compares VA[31:24]. In both cases the entry's range also applies. Entries outside the range are kept.
- R9: Code 3 invalidates every entry of the current context and keeps entries of other contexts.
- R10: Code 4 on a write invalidates every entry of any context, with effect from the next cycle. Codes 5 to 15 on a write change nothing.
- R11: A control read with code 4 returns the entry that matches the address in the current context, or zero if none matches. A control read with any other code returns zero.
- R12: If a control write and a fill arrive in the same cycle, the write is carried out and the fill is dropped.
- R13: Page, segment and region invalidates affect only entries of the current context.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| ctx_i | input | CTX_W | current context number |
| lk_valid_i | input | 1 | lookup request |
| lk_va_i | input | 32 | lookup virtual address |
| lk_hit_o | output | 1 | lookup hit |
| lk_miss_o | output | 1 | lookup miss, request to the walker |
| lk_pa_o | output | 32 | translated physical address |
| lk_pte_o | output | 32 | entry that hit |
| fill_i | input | 1 | fill request from the walker |
| fill_va_i | input | 32 | virtual address of the fill |
| fill_pte_i | input | 32 | entry to store |
| fill_lvl_i | input | 2 | level at which the walk ended (1 to 3) |
| ctl_en_i | input | 1 | control access strobe |
| ctl_rd_i | input | 1 | 1 = probe read, 0 = invalidate write |
| ctl_addr_i | input | 32 | control address, bits [11:8] select the operation |
| probe_data_o | output | 32 | probe result |

## Verification
The bench checks that each level uses the right tag bits at the edge of its range. A design that masks the tag wrongly would either hit the neighbouring page or segment, or miss inside a large mapping. Page invalidates are also aimed at addresses inside a 16 MiB entry; a design with no overlap rule would keep the stale mapping. The bench checks that entries of another context survive the invalidates that are limited by context, and that unused operation codes change nothing. It also issues a fill in the same cycle as an invalidate and expects the fill to be lost. Finally it fills the cache completely and then twice more. Here a wrong replacement pointer evicts the wrong entry, and the check of which old page still hits shows this.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int VA_W = 32;

  localparam logic [3:0] OP_PAGE   = 4'd0;
  localparam logic [3:0] OP_SEG    = 4'd1;
  localparam logic [3:0] OP_REGION = 4'd2;
  localparam logic [3:0] OP_CTX    = 4'd3;
  localparam logic [3:0] OP_ALL    = 4'd4;

  // tag bits covered by a mapping of the given walk level
  function automatic logic [VA_W-1:0] lvl_mask(input logic [1:0] lvl);
    case (lvl)
      2'd1:    return 32'hFF00_0000;
      2'd2:    return 32'hFFFC_0000;
      default: return 32'hFFFF_F000;
    endcase
  endfunction

  // tag bits compared by an address-ranged invalidate
  function automatic logic [VA_W-1:0] op_mask(input logic [3:0] op);
    case (op)
      OP_PAGE:   return 32'hFFFF_F000;
      OP_SEG:    return 32'hFFFC_0000;
      OP_REGION: return 32'hFF00_0000;
      default:   return 32'h0000_0000;
    endcase
  endfunction

  function automatic logic [VA_W-1:0] make_pa(input logic [31:0] pte,
                                              input logic [VA_W-1:0] va,
                                              input logic [1:0] lvl);
    logic [VA_W-1:0] m;
    m = lvl_mask(lvl);
    return ({pte[27:8], 12'h000} & m) | (va & ~m);
  endfunction
endpackage

// File: rtl/xlat_entry.sv
module xlat_entry
  import xlat_pkg::*;
#(
  parameter int CTX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CTX_W-1:0] ctx_i,
  input  logic             wr_i,
  input  logic [VA_W-1:0]  wr_va_i,
  input  logic [31:0]      wr_pte_i,
  input  logic [1:0]       wr_lvl_i,
  input  logic             inv_i,
  input  logic [3:0]       inv_op_i,
  input  logic [VA_W-1:0]  inv_va_i,
  input  logic [VA_W-1:0]  lk_va_i,
  input  logic [VA_W-1:0]  pr_va_i,
  output logic             vld_o,
  output logic             lk_hit_o,
  output logic             pr_hit_o,
  output logic [31:0]      pte_o,
  output logic [1:0]       lvl_o
);
  logic             vld_q;
  logic [CTX_W-1:0] ctx_q;
  logic [19:0]      tag_q;
  logic [31:0]      pte_q;
  logic [1:0]       lvl_q;
  logic [VA_W-1:0]  tag_full, emask;
  logic             ctx_eq, kill;

  assign tag_full = {tag_q, 12'h000};
  assign emask    = lvl_mask(lvl_q);
  assign ctx_eq   = (ctx_q == ctx_i);

  always_comb begin
    kill = 1'b0;
    if (inv_i && vld_q) begin
      if (inv_op_i == OP_ALL) kill = 1'b1;
      else if (ctx_eq) begin
        if (inv_op_i == OP_CTX) kill = 1'b1;
        else if (inv_op_i <= OP_REGION)
          kill = (((inv_va_i ^ tag_full) & emask & op_mask(inv_op_i)) == '0);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      ctx_q <= '0;
      tag_q <= '0;
      pte_q <= '0;
      lvl_q <= 2'd3;
    end else if (kill) begin
      vld_q <= 1'b0;
    end else if (wr_i) begin
      vld_q <= 1'b1;
      ctx_q <= ctx_i;
      tag_q <= wr_va_i[31:12];
      pte_q <= wr_pte_i;
      lvl_q <= wr_lvl_i;
    end
  end

  assign vld_o    = vld_q;
  assign lk_hit_o = vld_q && ctx_eq && (((lk_va_i ^ tag_full) & emask) == '0);
  assign pr_hit_o = vld_q && ctx_eq && (((pr_va_i ^ tag_full) & emask) == '0);
  assign pte_o    = pte_q;
  assign lvl_o    = lvl_q;

  // R7 R8 R9 R10
  entry_kill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kill |=> !vld_q);
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
  parameter int N_ENT = 8,
  localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_ENT-1:0] vld_i,
  input  logic             adv_i,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W-1:0] rr_q;
  logic             full;

  assign full = &vld_i;

  always_comb begin
    idx_o = rr_q;
    for (int i = N_ENT - 1; i >= 0; i--)
      if (!vld_i[i]) idx_o = IDX_W'(i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rr_q <= '0;
    else if (adv_i && full)
      rr_q <= (rr_q == IDX_W'(N_ENT - 1)) ? '0 : rr_q + 1'b1;
  end

  // R6
  rr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(adv_i && full) |=> $stable(rr_q));
  // R6
  pick_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !full |-> !vld_i[idx_o]);
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int N_ENT = 8,
  parameter int CTX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CTX_W-1:0] ctx_i,
  input  logic             lk_valid_i,
  input  logic [31:0]      lk_va_i,
  output logic             lk_hit_o,
  output logic             lk_miss_o,
  output logic [31:0]      lk_pa_o,
  output logic [31:0]      lk_pte_o,
  input  logic             fill_i,
  input  logic [31:0]      fill_va_i,
  input  logic [31:0]      fill_pte_i,
  input  logic [1:0]       fill_lvl_i,
  input  logic             ctl_en_i,
  input  logic             ctl_rd_i,
  input  logic [31:0]      ctl_addr_i,
  output logic [31:0]      probe_data_o
);
  localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1;

  logic             inv_go, probe_go, fill_go;
  logic [3:0]       op;
  logic [IDX_W-1:0] vic_idx;
  logic [N_ENT-1:0] e_vld, e_lk, e_pr;
  logic [31:0]      e_pte [N_ENT];
  logic [1:0]       e_lvl [N_ENT];
  logic             any_lk, any_pr;
  logic [31:0]      lk_pte, pr_pte;
  logic [1:0]       lk_lvl;

  assign op       = ctl_addr_i[11:8];
  assign inv_go   = ctl_en_i && !ctl_rd_i;
  assign probe_go = ctl_en_i && ctl_rd_i && (op == OP_ALL);
  assign fill_go  = fill_i && !inv_go;  // invalidate wins

  xlat_victim #(.N_ENT(N_ENT)) u_victim (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .vld_i (e_vld),
    .adv_i (fill_go),
    .idx_o (vic_idx)
  );

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    xlat_entry #(.CTX_W(CTX_W)) u_ent (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .ctx_i   (ctx_i),
      .wr_i    (fill_go && (vic_idx == IDX_W'(g))),
      .wr_va_i (fill_va_i),
      .wr_pte_i(fill_pte_i),
      .wr_lvl_i(fill_lvl_i),
      .inv_i   (inv_go),
      .inv_op_i(op),
      .inv_va_i(ctl_addr_i),
      .lk_va_i (lk_va_i),
      .pr_va_i (ctl_addr_i),
      .vld_o   (e_vld[g]),
      .lk_hit_o(e_lk[g]),
      .pr_hit_o(e_pr[g]),
      .pte_o   (e_pte[g]),
      .lvl_o   (e_lvl[g])
    );
  end

  // lowest matching index wins
  always_comb begin
    lk_pte = '0;
    lk_lvl = 2'd3;
    pr_pte = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (e_lk[i]) begin
        lk_pte = e_pte[i];
        lk_lvl = e_lvl[i];
      end
      if (e_pr[i]) pr_pte = e_pte[i];
    end
  end

  assign any_lk       = |e_lk;
  assign any_pr       = |e_pr;
  assign lk_hit_o     = lk_valid_i && any_lk;
  assign lk_miss_o    = lk_valid_i && !any_lk;
  assign lk_pte_o     = lk_hit_o ? lk_pte : '0;
  assign lk_pa_o      = lk_hit_o ? make_pa(lk_pte, lk_va_i, lk_lvl) : '0;
  assign probe_data_o = (probe_go && any_pr) ? pr_pte : '0;

  // R10
  inv_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inv_go && op == OP_ALL) |=> (e_vld == '0));
  // R12
  inv_beats_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inv_go && fill_i) |=> ($countones(e_vld) <= $countones($past(e_vld))));
  // R6
  fill_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_go |=> (e_vld != '0));
  // R11
  probe_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (probe_data_o != '0) |-> probe_go);
endmodule

// File: tb/xlat_cache_test.sv
module xlat_cache_test;
  typedef struct packed {
    logic [7:0]  ctx;
    logic [31:0] va;
    logic        hit;
    logic [31:0] pa;
  } lk_vec_t;

  // lookups after the base fill set (R2 R3 R4 R5)
  localparam lk_vec_t VECS [9] = '{
    '{8'd1, 32'h1234_5678, 1'b1, 32'hAAAA_A678},
    '{8'd1, 32'h1234_6678, 1'b0, 32'h0},
    '{8'd1, 32'h4007_1234, 1'b1, 32'hBBBB_1234},
    '{8'd1, 32'h4008_0000, 1'b0, 32'h0},
    '{8'd1, 32'h80AB_CDEF, 1'b1, 32'hCCAB_CDEF},
    '{8'd1, 32'h8100_0000, 1'b0, 32'h0},
    '{8'd2, 32'h1234_5678, 1'b1, 32'hDDDD_D678},
    '{8'd2, 32'h80AB_CDEF, 1'b0, 32'h0},
    '{8'd3, 32'h1234_5678, 1'b0, 32'h0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  ctx = '0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_va = '0;
  logic        lk_hit, lk_miss;
  logic [31:0] lk_pa, lk_pte;
  logic        fill_en = 1'b0;
  logic [31:0] fill_va = '0, fill_pte = '0;
  logic [1:0]  fill_lvl = 2'd3;
  logic        ctl_en = 1'b0, ctl_rd = 1'b0;
  logic [31:0] ctl_addr = '0;
  logic [31:0] probe_data;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  xlat_cache uut (
    .clk_i(clk), .rst_ni(rst_n), .ctx_i(ctx),
    .lk_valid_i(lk_valid), .lk_va_i(lk_va), .lk_hit_o(lk_hit), .lk_miss_o(lk_miss),
    .lk_pa_o(lk_pa), .lk_pte_o(lk_pte),
    .fill_i(fill_en), .fill_va_i(fill_va), .fill_pte_i(fill_pte), .fill_lvl_i(fill_lvl),
    .ctl_en_i(ctl_en), .ctl_rd_i(ctl_rd), .ctl_addr_i(ctl_addr), .probe_data_o(probe_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic fill(input logic [7:0] c, input logic [31:0] va, input logic [31:0] pte,
                      input logic [1:0] lv);
    @(negedge clk);
    ctx = c; fill_en = 1'b1; fill_va = va; fill_pte = pte; fill_lvl = lv;
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  task automatic inv(input logic [7:0] c, input logic [31:0] addr);
    @(negedge clk);
    ctx = c; ctl_en = 1'b1; ctl_rd = 1'b0; ctl_addr = addr;
    @(negedge clk);
    ctl_en = 1'b0;
  endtask

  task automatic look(input string tag, input logic [7:0] c, input logic [31:0] va,
                      input logic hit, input logic [31:0] pa);
    @(negedge clk);
    ctx = c; lk_valid = 1'b1; lk_va = va;
    #1;
    chk({tag, " hit"}, {31'b0, lk_hit}, {31'b0, hit});
    chk({tag, " miss"}, {31'b0, lk_miss}, {31'b0, !hit});
    if (hit) chk({tag, " pa"}, lk_pa, pa);
    lk_valid = 1'b0;
  endtask

  task automatic probe(input string tag, input logic [7:0] c, input logic [31:0] addr,
                       input logic [31:0] exp);
    @(negedge clk);
    ctx = c; ctl_en = 1'b1; ctl_rd = 1'b1; ctl_addr = addr;
    #1;
    chk(tag, probe_data, exp);
    ctl_en = 1'b0; ctl_rd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1
    look("R1 empty", 8'd1, 32'h1234_5678, 1'b0, 32'h0);
    probe("R1 probe empty", 8'd1, 32'h1234_5400, 32'h0);
    // R5 idle
    @(negedge clk); lk_valid = 1'b0; #1;
    chk("R5 idle flags", {30'b0, lk_hit, lk_miss}, 32'h0);

    fill(8'd1, 32'h1234_5000, 32'h0AAA_AA0E, 2'd3);
    fill(8'd1, 32'h4004_0000, 32'h0BBB_BB0E, 2'd2);
    fill(8'd1, 32'h8000_0000, 32'h0CCC_CC0E, 2'd1);
    fill(8'd2, 32'h1234_5000, 32'h0DDD_DD0E, 2'd3);

    for (int i = 0; i < 9; i++)
      look($sformatf("R2/R3/R4/R5 vec%0d", i), VECS[i].ctx, VECS[i].va, VECS[i].hit, VECS[i].pa);
    @(negedge clk); ctx = 8'd1; lk_valid = 1'b1; lk_va = 32'h1234_5678; #1;
    chk("R2 pte", lk_pte, 32'h0AAA_AA0E);
    lk_valid = 1'b0;

    // R11
    probe("R11 probe l3", 8'd1, 32'h1234_5400, 32'h0AAA_AA0E);
    probe("R11 probe l2", 8'd1, 32'h4007_1400, 32'h0BBB_BB0E);
    probe("R11 probe none", 8'd1, 32'h5555_5400, 32'h0);
    probe("R11 probe other code", 8'd1, 32'h1234_5000, 32'h0);

    // R10 unused code
    inv(8'd1, 32'h1234_5500);
    look("R10 code5 no effect", 8'd1, 32'h1234_5678, 1'b1, 32'hAAAA_A678);
    // R7 R13
    inv(8'd1, 32'h1234_5000);
    look("R7 page gone", 8'd1, 32'h1234_5678, 1'b0, 32'h0);
    look("R13 other ctx kept", 8'd2, 32'h1234_5678, 1'b1, 32'hDDDD_D678);
    inv(8'd1, 32'h8012_3000);
    look("R7 overlap large", 8'd1, 32'h80AB_CDEF, 1'b0, 32'h0);
    // R8 segment
    inv(8'd1, 32'h4008_0100);
    look("R8 seg outside kept", 8'd1, 32'h4007_1234, 1'b1, 32'hBBBB_1234);
    inv(8'd1, 32'h4004_0100);
    look("R8 seg gone", 8'd1, 32'h4007_1234, 1'b0, 32'h0);
    // R8 region
    fill(8'd1, 32'h1234_5000, 32'h0AAA_AA0E, 2'd3);
    fill(8'd1, 32'h12FF_F000, 32'h0111_110E, 2'd3);
    look("R8 region pre", 8'd1, 32'h12FF_F004, 1'b1, 32'h1111_1004);
    inv(8'd1, 32'h1200_0200);
    look("R8 region a", 8'd1, 32'h1234_5678, 1'b0, 32'h0);
    look("R8 region b", 8'd1, 32'h12FF_F004, 1'b0, 32'h0);
    look("R13 region ctx2 kept", 8'd2, 32'h1234_5678, 1'b1, 32'hDDDD_D678);
    // R9
    fill(8'd1, 32'h7000_0000, 32'h0777_770E, 2'd3);
    inv(8'd2, 32'h0000_0300);
    look("R9 ctx2 gone", 8'd2, 32'h1234_5678, 1'b0, 32'h0);
    look("R9 ctx1 kept", 8'd1, 32'h7000_0ABC, 1'b1, 32'h7777_7ABC);
    // R10 entire
    inv(8'd2, 32'h0000_0400);
    look("R10 all gone", 8'd1, 32'h7000_0ABC, 1'b0, 32'h0);
    probe("R10 probe after all", 8'd1, 32'h7000_0400, 32'h0);
    // R12
    @(negedge clk);
    ctx = 8'd1; fill_en = 1'b1; fill_va = 32'h3000_0000; fill_pte = 32'h0333_330E; fill_lvl = 2'd3;
    ctl_en = 1'b1; ctl_rd = 1'b0; ctl_addr = 32'h9999_9000;
    @(negedge clk);
    fill_en = 1'b0; ctl_en = 1'b0;
    look("R12 fill dropped", 8'd1, 32'h3000_0000, 1'b0, 32'h0);
    // R6
    for (int i = 0; i < 8; i++)
      fill(8'd1, 32'h1000_0000 + (i << 12), ((32'h100 + i) << 8) | 32'h0E, 2'd3);
    for (int i = 0; i < 8; i++)
      look($sformatf("R6 full e%0d", i), 8'd1, 32'h1000_0010 + (i << 12), 1'b1,
           ((32'h100 + i) << 12) | 32'h10);
    fill(8'd1, 32'h2000_0000, 32'h0EEE_EE0E, 2'd3);
    look("R6 rr0 evicted", 8'd1, 32'h1000_0010, 1'b0, 32'h0);
    look("R6 e1 kept", 8'd1, 32'h1000_1010, 1'b1, 32'h0010_1010);
    look("R6 new hit", 8'd1, 32'h2000_0010, 1'b1, 32'hEEEE_E010);
    fill(8'd1, 32'h2100_0000, 32'h0FFF_FF0E, 2'd3);
    look("R6 rr1 evicted", 8'd1, 32'h1000_1010, 1'b0, 32'h0);
    look("R6 e2 kept", 8'd1, 32'h1000_2010, 1'b1, 32'h0010_2010);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule